// File: doc/BRIEF.md
# Page-Buffered Self-Timed Byte Memory Controller

This block is the control side of a byte-wide nonvolatile memory whose writes are collected into a page and then committed by a self-timed programming cycle. It runs on one clock and samples three active-low strobes: chip select, output enable and write enable. It also takes an address bus and a data bus that is split into input, output and output-enable signals. The storage array is a register file built inside the block.

A write cycle loads one byte into a page buffer. The first load of an operation fixes the page. Each later load in that page must start before a retriggerable window runs out. When the window expires with no new load, the block raises busy for a fixed number of cycles and then moves the loaded bytes into the array. While busy, reads do not return array data. They return a status byte instead: bit 7 is the inverse of bit 7 of the last byte loaded, bit 6 flips after each read, and the low bits are zero. Host software can poll either bit to find out when the write has finished. Cycle counts take the place of the microsecond and millisecond times of a real part.

Top module: `pagewr_ctrl`

## Requirements
- R1: `bus_oe` is 1 only while `cs_n` and `rd_en_n` are both 0, and in that case it is 1; at all other times it is 0.
- R2: A write cycle occurs only while `cs_n` and `wr_en_n` are both 0 and `rd_en_n` is 1. Holding all three strobes low stores no byte and starts no programming.
- R3: The address is taken in the first cycle in which the write condition of R2 holds (the later of the falling edges of `cs_n` and `wr_en_n`). The data is the `bus_in` value in the last cycle in which that condition holds (the earlier of the two rising edges). Address changes before that first cycle and data changes after that last cycle have no effect.
- R4: A page holds 2**PAGE_W bytes (256 by default). `addr[ADDR_W-1:PAGE_W]` selects the page and `addr[PAGE_W-1:0]` selects the byte. A full page of loads lands at the addressed locations.
- R5: The first load of an operation fixes the page. A later load to a different page is not stored and does not restart the window.
- R6: `busy` rises exactly WIN_CYC clock cycles after the first write cycle of the last accepted load, provided the strobes have been released by then. Every accepted load restarts this window.
- R7: `busy` stays high for exactly PROG_CYC cycles. When it falls, the loaded bytes are in the array and every byte of the page that was not loaded keeps its old value.
- R8: While `busy` is high, bit 7 of a read is the inverse of bit 7 of the last byte loaded. After `busy` falls, a read returns the true stored byte.
- R9: While `busy` is high, bit 6 of a read is 0 on the first read of the programming cycle and flips on each following read.
- R10: While `busy` is high, bits 5 to 0 of every read are 0.
- R11: A write cycle that starts while `busy` is high is ignored. It stores nothing and starts no new programming cycle.
- R12: After reset the array reads all zero and `busy` is 0. Outside programming, a read returns the stored byte and stays steady while the address is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears array and state |
| cs_n | input | 1 | Active-low chip select |
| rd_en_n | input | 1 | Active-low output enable |
| wr_en_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Byte address (page above PAGE_W, byte below) |
| bus_in | input | 8 | Data bus, input side |
| bus_out | output | 8 | Data bus, output side: array byte or status |
| bus_oe | output | 1 | Data bus drive enable; bus is high-impedance when 0 |
| busy | output | 1 | High during the internal programming cycle |

## Verification
Every byte of all four pages of the default array is loaded with an arithmetic pattern, and the whole array is read back. A wrong page or byte split, or a lost load, shows up as a mismatch at a computed address. Two partial-page operations confirm that untouched bytes keep their values. Spaced loads separate a restarting window from a free-running one, and a load to a foreign page shows whether such a load wrongly restarts the window. Status reads are made with bit 7 of the last byte both clear and set, so an inverted bit can be told apart from a constant. A write cycle whose address changes before it starts, and whose data changes after its enables rise, separates correct capture points from sampling at the wrong edge.

// File: rtl/pagewr_ctrl.sv
module pagewr_ctrl #(
  parameter int ADDR_W   = 10,
  parameter int PAGE_W   = 8,
  parameter int WIN_CYC  = 16,
  parameter int PROG_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_en_n,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        bus_in,
  output logic [7:0]        bus_out,
  output logic              bus_oe,
  output logic              busy
);
  localparam int PG_BYTES = 1 << PAGE_W;
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int PG_W     = ADDR_W - PAGE_W;
  localparam int WC_W     = $clog2(WIN_CYC + 1);
  localparam int PC_W     = $clog2(PROG_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} st_t;

  st_t                st;
  logic               wr_q, rd_q, acc, tog;
  logic [PG_W-1:0]    pg;
  logic [PAGE_W-1:0]  a_lat;
  logic [7:0]         d_lat, last;
  logic [WC_W-1:0]    wcnt;
  logic [PC_W-1:0]    pcnt;
  logic [PG_BYTES-1:0] mask;
  logic [7:0]         pbuf [PG_BYTES];
  logic [7:0]         mem  [DEPTH];

  wire wr_act   = !cs_n && !wr_en_n && rd_en_n;
  wire rd       = !cs_n && !rd_en_n;
  wire wr_start = wr_act && !wr_q;
  wire wr_end   = !wr_act && wr_q;
  wire page_ok  = (st == S_IDLE) || (st == S_LOAD && addr[ADDR_W-1:PAGE_W] == pg);

  assign busy    = (st == S_PROG);
  assign bus_oe  = rd;
  assign bus_out = busy ? {~last[7], tog, 6'b0} : mem[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      wr_q  <= 1'b0;
      rd_q  <= 1'b0;
      acc   <= 1'b0;
      tog   <= 1'b0;
      pg    <= '0;
      a_lat <= '0;
      d_lat <= '0;
      last  <= '0;
      wcnt  <= '0;
      pcnt  <= '0;
      mask  <= '0;
      for (int i = 0; i < PG_BYTES; i++) pbuf[i] <= '0;
      for (int j = 0; j < DEPTH; j++) mem[j] <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd;
      if (wr_act) d_lat <= bus_in;

      case (st)
        S_LOAD: begin
          if (wcnt != WC_W'(WIN_CYC - 1)) wcnt <= wcnt + 1'b1;
          else if (!wr_act) begin
            st   <= S_PROG;
            pcnt <= '0;
            tog  <= 1'b0;
          end
        end
        S_PROG: begin
          if (rd_q && !rd) tog <= ~tog;
          if (pcnt == PC_W'(PROG_CYC - 1)) begin
            st <= S_IDLE;
            for (int i = 0; i < PG_BYTES; i++)
              if (mask[i]) mem[{pg, PAGE_W'(i)}] <= pbuf[i];
            mask <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        default: ;
      endcase

      if (wr_end && acc) begin
        pbuf[a_lat] <= d_lat;
        mask[a_lat] <= 1'b1;
        last        <= d_lat;
        acc         <= 1'b0;
      end

      if (wr_start) begin
        acc <= page_ok;
        if (page_ok) begin
          a_lat <= addr[PAGE_W-1:0];
          pg    <= addr[ADDR_W-1:PAGE_W];
          wcnt  <= '0;
          st    <= S_LOAD;
        end
      end
    end
  end
endmodule

module pagewr_ctrl_chk #(
  parameter int ADDR_W   = 10,
  parameter int PROG_CYC = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        bus_out,
  input logic              bus_oe,
  input logic              busy
);
  logic [31:0] bcnt;
  logic        oe_q, seen, prev6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt  <= '0;
      oe_q  <= 1'b0;
      seen  <= 1'b0;
      prev6 <= 1'b0;
    end else begin
      bcnt <= busy ? bcnt + 1 : '0;
      oe_q <= bus_oe;
      if (!busy) seen <= 1'b0;
      else if (bus_oe && !oe_q) begin
        seen  <= 1'b1;
        prev6 <= bus_out[6];
      end
    end
  end

  a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy)) |-> (bcnt == PROG_CYC));

  a_r9_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_oe && !oe_q && seen) |-> (bus_out[6] != prev6));

  a_r10_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_oe) |-> (bus_out[5:0] == 6'd0));

  a_r12_steady_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && bus_oe && $past(bus_oe) && $stable(addr)) |-> $stable(bus_out));
endmodule

bind pagewr_ctrl pagewr_ctrl_chk #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .bus_out(bus_out), .bus_oe(bus_oe), .busy(busy)
);

// File: tb/tb_pagewr_ctrl.sv
module tb_pagewr_ctrl;
  localparam int AW = 10, PW = 8, WIN = 16, PROG = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rd_en_n = 1'b1, wr_en_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] bus_in = '0;
  logic [7:0] bus_out;
  logic bus_oe, busy;
  int cyc = 0, n_chk = 0, n_bad = 0;
  logic [7:0] exp_mem [1<<AW];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pagewr_ctrl #(.ADDR_W(AW), .PAGE_W(PW), .WIN_CYC(WIN), .PROG_CYC(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_en_n(rd_en_n), .wr_en_n(wr_en_n),
    .addr(addr), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .busy(busy));

  task automatic chk(input string req, input int got, input int expv);
    n_chk++;
    if (got != expv) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", req, got, expv, cyc);
    end
  endtask

  task automatic ld(input logic [AW-1:0] a, input logic [7:0] d, output int t0);
    @(negedge clk); addr = a; bus_in = d; rd_en_n = 1'b1; cs_n = 1'b0; wr_en_n = 1'b0;
    @(negedge clk); cs_n = 1'b1; wr_en_n = 1'b1; bus_in = ~d; t0 = cyc;
  endtask

  task automatic rdb(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; cs_n = 1'b0; rd_en_n = 1'b0;
    @(negedge clk); v = bus_out; chk("R1 oe during read", int'(bus_oe), 1);
    cs_n = 1'b1; rd_en_n = 1'b1;
  endtask

  task automatic wait_busy(output int t);
    while (!busy) @(negedge clk);
    t = cyc;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic cmp_range(input string req, input int lo, input int hi);
    logic [7:0] v;
    for (int k = lo; k < hi; k++) begin
      rdb(AW'(k), v);
      chk(req, int'(v), int'(exp_mem[k]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int t0, tb, n;
    logic [7:0] v;
    for (int k = 0; k < (1<<AW); k++) exp_mem[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    chk("R12 busy after reset", int'(busy), 0);
    chk("R1 oe idle", int'(bus_oe), 0);
    rdb(0, v); chk("R12 reset zero", int'(v), 0);
    rdb(AW'(1023), v); chk("R12 reset zero", int'(v), 0);

    // R1: only cs and oe both low drive the bus
    @(negedge clk); cs_n = 1'b0; rd_en_n = 1'b1;
    #1 chk("R1 cs only", int'(bus_oe), 0);
    cs_n = 1'b1; rd_en_n = 1'b0;
    #1 chk("R1 oe only", int'(bus_oe), 0);
    cs_n = 1'b0;
    #1 chk("R1 both low", int'(bus_oe), 1);
    cs_n = 1'b1; rd_en_n = 1'b1;

    // R4/R6/R7: full-page sweep over every page
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 256; i++) begin
        logic [7:0] d;
        d = 8'((i * 37 + p * 11 + 5) & 255);
        ld(AW'(p * 256 + i), d, t0);
        exp_mem[p * 256 + i] = d;
      end
      wait_busy(tb);
      chk("R6 window from last load", tb - t0, WIN);
      n = 0;
      while (busy) begin n++; @(negedge clk); end
      chk("R7 busy length", n, PROG);
    end
    cmp_range("R4 full array sweep", 0, 1024);

    // R7: partial page keeps untouched bytes
    ld(AW'(256 + 3), 8'hA5, t0); exp_mem[259] = 8'hA5;
    ld(AW'(256 + 200), 8'h3C, t0); exp_mem[456] = 8'h3C;
    wait_busy(tb); wait_idle();
    cmp_range("R7 partial page", 256, 512);

    // R8/R9/R10/R11: status during programming, bit 7 clear in data
    ld(AW'(512 + 10), 8'h35, t0); exp_mem[522] = 8'h35;
    wait_busy(tb);
    rdb(AW'(522), v);
    chk("R8 poll bit7 inverted", int'(v[7]), 1);
    chk("R9 toggle first", int'(v[6]), 0);
    chk("R10 low bits zero", int'(v[5:0]), 0);
    rdb(AW'(522), v); chk("R9 toggle second", int'(v[6]), 1);
    rdb(AW'(7), v);   chk("R9 toggle third", int'(v[6]), 0);
    chk("R10 low bits zero", int'(v[5:0]), 0);
    ld(AW'(512 + 11), 8'h99, t0);
    wait_idle();
    rdb(AW'(522), v); chk("R8 true data after", int'(v), 8'h35);
    rdb(AW'(523), v); chk("R11 write in busy ignored", int'(v), int'(exp_mem[523]));
    repeat (WIN + 5) @(negedge clk);
    chk("R11 no new programming", int'(busy), 0);

    // R8: bit 7 set in data
    ld(AW'(512 + 20), 8'hC3, t0); exp_mem[532] = 8'hC3;
    wait_busy(tb);
    rdb(AW'(532), v); chk("R8 poll bit7 inverted set", int'(v[7]), 0);
    wait_idle();
    rdb(AW'(532), v); chk("R8 true data after set", int'(v), 8'hC3);

    // R5: foreign-page load ignored, no window restart
    ld(AW'(768), 8'h5A, t0); exp_mem[768] = 8'h5A;
    repeat (4) @(negedge clk);
    ld(AW'(1), 8'hEE, n);
    wait_busy(tb);
    chk("R5 window not restarted", tb - t0, WIN);
    wait_idle();
    rdb(AW'(768), v); chk("R5 own page stored", int'(v), 8'h5A);
    rdb(AW'(1), v);   chk("R5 foreign load dropped", int'(v), int'(exp_mem[1]));

    // R6: spaced loads restart the window
    ld(AW'(256 + 50), 8'h11, t0); exp_mem[306] = 8'h11;
    repeat (WIN - 5) @(negedge clk);
    chk("R6 not busy mid window", int'(busy), 0);
    ld(AW'(256 + 51), 8'h22, t0); exp_mem[307] = 8'h22;
    repeat (WIN - 5) @(negedge clk);
    chk("R6 not busy after restart", int'(busy), 0);
    ld(AW'(256 + 52), 8'h33, t0); exp_mem[308] = 8'h33;
    wait_busy(tb);
    chk("R6 restart timing", tb - t0, WIN);
    wait_idle();
    cmp_range("R6 spaced loads stored", 306, 309);

    // R2: all strobes low is not a write
    @(negedge clk); addr = AW'(600); bus_in = 8'h77; cs_n = 1'b0; wr_en_n = 1'b0; rd_en_n = 1'b0;
    @(negedge clk); @(negedge clk);
    cs_n = 1'b1; wr_en_n = 1'b1; rd_en_n = 1'b1;
    repeat (WIN + 5) @(negedge clk);
    chk("R2 no programming", int'(busy), 0);
    rdb(AW'(600), v); chk("R2 no store", int'(v), int'(exp_mem[600]));

    // R3: address at later fall, data at earlier rise
    @(negedge clk); addr = AW'(40); bus_in = 8'h01; rd_en_n = 1'b1; wr_en_n = 1'b0; cs_n = 1'b1;
    @(negedge clk); addr = AW'(41); bus_in = 8'h6B; cs_n = 1'b0;
    @(negedge clk); wr_en_n = 1'b1; bus_in = 8'hF0; addr = AW'(42);
    @(negedge clk); cs_n = 1'b1;
    exp_mem[41] = 8'h6B;
    wait_busy(tb); wait_idle();
    cmp_range("R3 capture points", 40, 43);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule